// File: doc/BRIEF.md
# Addressable Character FIFO Host Port

This block is a synchronous character FIFO with a host port that moves data only when the port has been addressed. Each character is 12 bits wide, which includes the command/data tag, and the FIFO holds 256 characters. A host can write characters and read them back only after an active-low address-match input has addressed the port. Once selected, the port moves one character on every clock for which the enable stays active.

A static mode input selects one of two handshake styles. In the low-active style, the enables, full flag and empty flag are all active low. In the chaining style, which is meant for cascading with external FIFOs, those same signals are active high. The half-full flag is active low in both styles. The flags are three-state at the chip edge, so each flag value comes with an output-enable that is driven only while the port is addressed.

A flush request clears the FIFO, but only when the port is addressed and the write enable is idle. While the request stays high, the port shows a held state with full and half-full both asserted. This held state is distinct from a full state reached by writing 256 characters.

Top module: `addr_char_fifo`

## Requirements
- R1: After the synchronous reset, the FIFO is empty, the empty flag is asserted, full and half-full are deasserted, `flag_oe` is 0 and `rd_data` is 0.
- R2: With `casc_mode`=0, `wr_en_pin`, `rd_en_pin`, `full_pin` and `empty_pin` are active low. With `casc_mode`=1 they are active high. `half_n_pin` is active low in both modes.
- R3: A character is written on the same edge that samples the write enable active together with `addr_n`=0. After that, one character is written on every following edge while the write enable stays active, whatever the value of `addr_n`.
- R4: A write enable that becomes active while `addr_n`=1, with no selection in progress, writes nothing.
- R5: A read needs arming first: an edge that samples `addr_n`=0 with the read enable idle. Each following edge with the read enable active pops one character, which appears on `rd_data` after that edge, in write order. A read enable already active when `addr_n` goes low is ignored until the enable goes idle and becomes active again.
- R6: `flag_oe` is 1 after an edge that sampled `addr_n`=0, and 0 after an edge that sampled `addr_n`=1.
- R7: Half-full is asserted exactly when the occupancy is 128 or more, outside the flush hold.
- R8: Full is asserted at 256 characters. Writes while full and reads while empty are ignored: the contents, the order and `rd_data` are kept.
- R9: If `flush_req`=1, `addr_n`=0 and the write enable is idle on the same edge, all contents are discarded. For as long as `flush_req` stays 1, full and half-full are asserted, empty is deasserted, and writes and reads are ignored. After `flush_req` is released, the FIFO reports empty.
- R10: A `flush_req` sampled while the write enable is active has no effect: the contents are kept and the write proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| casc_mode | input | 1 | 0 selects the low-active style, 1 selects the chaining style |
| addr_n | input | 1 | Address match, active low |
| wr_en_pin | input | 1 | Write enable, polarity set by mode |
| wr_data | input | 12 | Character to write |
| rd_en_pin | input | 1 | Read enable, polarity set by mode |
| flush_req | input | 1 | Flush request, active high |
| rd_data | output | 12 | Last character popped |
| full_pin | output | 1 | Full flag, polarity set by mode |
| half_n_pin | output | 1 | Half-full flag, active low |
| empty_pin | output | 1 | Empty flag, polarity set by mode |
| flag_oe | output | 1 | Drive enable for the three flags |

## Verification
The assertions check on every cycle that occupancy never exceeds the depth, that a full or empty FIFO does not change without the operation that could change it, that half-full tracks the occupancy threshold, that the flush hold shows the forced full indication, that no write happens without a selection, and that a hold only starts with the write enable idle. Only the bench scenarios can show the selection timing across several edges, the arming sequence for reads, the first-in first-out order after a complete fill, the flag polarity in each mode, and that characters are actually discarded by a valid flush and kept after an invalid one.

// File: rtl/addr_char_fifo_pkg.sv
package addr_char_fifo_pkg;
  // Converts between an internal active-high level and a mode-dependent pin level.
  // The conversion is the same in both directions.
  function automatic logic apply_pol(input logic lvl, input logic casc);
    return casc ? lvl : ~lvl;
  endfunction
endpackage

// File: rtl/acf_mem.sv
module acf_mem #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // The output register has a synchronous reset.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/acf_select.sv
module acf_select #(
  parameter bit NEED_ARM = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic addr_n,
  input  logic en_act,
  output logic go,
  output logic sel_q
);
  generate
    if (NEED_ARM) begin : g_armed
      // The port is armed by an address match seen while the enable is idle.
      logic arm_q;
      assign go = en_act & (arm_q | sel_q);
      always_ff @(posedge clk) begin
        if (rst) arm_q <= 1'b0;
        else     arm_q <= ~en_act & ~addr_n;
      end
    end else begin : g_direct
      // Selection takes effect on the same edge as the address match.
      assign go = en_act & (~addr_n | sel_q);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= go;
  end
endmodule

// File: rtl/acf_flags.sv
module acf_flags #(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          casc_mode,
  input  logic          addr_n,
  input  logic [CW-1:0] occ_n,
  input  logic          hold_n,
  output logic          full_pin,
  output logic          half_n_pin,
  output logic          empty_pin,
  output logic          flag_oe
);
  import addr_char_fifo_pkg::*;

  logic full_l, half_l, empty_l;

  always_comb begin
    full_l  = hold_n | (occ_n == CW'(DEPTH));
    half_l  = hold_n | (occ_n >= CW'(HALF));
    empty_l = ~hold_n & (occ_n == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_pin   <= apply_pol(1'b0, casc_mode);
      half_n_pin <= 1'b1;
      empty_pin  <= apply_pol(1'b1, casc_mode);
      flag_oe    <= 1'b0;
    end else begin
      full_pin   <= apply_pol(full_l, casc_mode);
      half_n_pin <= ~half_l;
      empty_pin  <= apply_pol(empty_l, casc_mode);
      flag_oe    <= ~addr_n;
    end
  end
endmodule

// File: rtl/addr_char_fifo.sv
module addr_char_fifo #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             casc_mode,
  input  logic             addr_n,
  input  logic             wr_en_pin,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en_pin,
  input  logic             flush_req,
  output logic [WIDTH-1:0] rd_data,
  output logic             full_pin,
  output logic             half_n_pin,
  output logic             empty_pin,
  output logic             flag_oe
);
  import addr_char_fifo_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          wr_act, rd_act;
  logic          wr_go, rd_go, wr_sel_q, rd_sel_q;
  logic          flush_ok, hold_q, hold_n;
  logic          push_do, pop_do;
  logic [CW-1:0] occ, occ_n;
  logic [AW-1:0] wptr, rptr;

  assign wr_act = apply_pol(wr_en_pin, casc_mode);
  assign rd_act = apply_pol(rd_en_pin, casc_mode);

  acf_select #(.NEED_ARM(1'b0)) u_wsel (
    .clk(clk), .rst(rst), .addr_n(addr_n), .en_act(wr_act),
    .go(wr_go), .sel_q(wr_sel_q)
  );

  acf_select #(.NEED_ARM(1'b1)) u_rsel (
    .clk(clk), .rst(rst), .addr_n(addr_n), .en_act(rd_act),
    .go(rd_go), .sel_q(rd_sel_q)
  );

  always_comb begin
    flush_ok = flush_req & ~addr_n & ~wr_act;
    hold_n   = flush_ok | (hold_q & flush_req);
    push_do  = wr_go & (occ != CW'(DEPTH)) & ~hold_q & ~flush_ok;
    pop_do   = rd_go & (occ != '0) & ~hold_q & ~flush_ok;
    if (flush_ok) occ_n = '0;
    else          occ_n = occ + CW'(push_do) - CW'(pop_do);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ    <= '0;
      hold_q <= 1'b0;
      wptr   <= '0;
      rptr   <= '0;
    end else begin
      occ    <= occ_n;
      hold_q <= hold_n;
      if (flush_ok) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (push_do) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        if (pop_do)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
    end
  end

  acf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst(rst), .we(push_do), .waddr(wptr), .wdata(wr_data),
    .re(pop_do), .raddr(rptr), .rdata(rd_data)
  );

  acf_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .casc_mode(casc_mode), .addr_n(addr_n),
    .occ_n(occ_n), .hold_n(hold_n),
    .full_pin(full_pin), .half_n_pin(half_n_pin), .empty_pin(empty_pin),
    .flag_oe(flag_oe)
  );
endmodule

// File: rtl/addr_char_fifo_chk.sv
module addr_char_fifo_chk #(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input logic          clk,
  input logic          rst,
  input logic          casc_mode,
  input logic          addr_n,
  input logic          wr_en_pin,
  input logic          full_pin,
  input logic          half_n_pin,
  input logic [CW-1:0] occ,
  input logic          hold_q,
  input logic          wr_sel_q,
  input logic          push_do,
  input logic          pop_do,
  input logic          flush_ok
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH)); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(DEPTH) && !pop_do && !flush_ok) |=> (occ == CW'(DEPTH))); // R8
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (occ == '0 && !push_do) |=> (occ == '0)); // R8
  AST_HALF_ABOVE: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && occ >= CW'(HALF)) |-> (half_n_pin == 1'b0)); // R7
  AST_HALF_BELOW: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && occ < CW'(HALF)) |-> (half_n_pin == 1'b1)); // R7
  AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> (half_n_pin == 1'b0 && full_pin == casc_mode)); // R9
  AST_NO_UNSELECTED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (addr_n && !wr_sel_q) |-> !push_do); // R4
  AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_q) |-> ($past(wr_en_pin) == ~$past(casc_mode))); // R10
endmodule

bind addr_char_fifo addr_char_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .casc_mode(casc_mode), .addr_n(addr_n),
  .wr_en_pin(wr_en_pin), .full_pin(full_pin), .half_n_pin(half_n_pin),
  .occ(occ), .hold_q(hold_q), .wr_sel_q(wr_sel_q), .push_do(push_do),
  .pop_do(pop_do), .flush_ok(flush_ok)
);

// File: tb/addr_char_fifo_bench.sv
module addr_char_fifo_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        casc_mode = 1'b0;
  logic        addr_n = 1'b1;
  logic        wr_en_pin = 1'b1;
  logic [11:0] wr_data = '0;
  logic        rd_en_pin = 1'b1;
  logic        flush_req = 1'b0;
  logic [11:0] rd_data;
  logic        full_pin, half_n_pin, empty_pin, flag_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_char_fifo u_addr_char_fifo (
    .clk(clk), .rst(rst), .casc_mode(casc_mode), .addr_n(addr_n),
    .wr_en_pin(wr_en_pin), .wr_data(wr_data), .rd_en_pin(rd_en_pin),
    .flush_req(flush_req), .rd_data(rd_data), .full_pin(full_pin),
    .half_n_pin(half_n_pin), .empty_pin(empty_pin), .flag_oe(flag_oe)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        a, we, re, fl;
    logic [11:0] d;
    logic        e_full, e_half, e_empty, e_oe, chk_rd;
    logic [11:0] e_rd;
  } vec_t;

  // Low-active mode: pins full=~full, half=~half, empty=~empty.
  localparam vec_t VECS [12] = '{
    '{4'd1, 1'b1,1'b1,1'b1,1'b0, 12'h000, 1'b1,1'b1,1'b0,1'b0,1'b1, 12'h000}, // R1 idle
    '{4'd4, 1'b1,1'b0,1'b1,1'b0, 12'h111, 1'b1,1'b1,1'b0,1'b0,1'b0, 12'h000}, // R4 no select
    '{4'd3, 1'b0,1'b0,1'b1,1'b0, 12'h0A1, 1'b1,1'b1,1'b1,1'b1,1'b0, 12'h000}, // R3 same-edge write
    '{4'd6, 1'b1,1'b0,1'b1,1'b0, 12'h0A2, 1'b1,1'b1,1'b1,1'b0,1'b0, 12'h000}, // R3 R6 held write
    '{4'd3, 1'b1,1'b1,1'b1,1'b0, 12'h000, 1'b1,1'b1,1'b1,1'b0,1'b0, 12'h000}, // R3 deselect
    '{4'd4, 1'b1,1'b0,1'b1,1'b0, 12'h0A3, 1'b1,1'b1,1'b1,1'b0,1'b0, 12'h000}, // R4 ignored
    '{4'd5, 1'b0,1'b1,1'b0,1'b0, 12'h000, 1'b1,1'b1,1'b1,1'b1,1'b1, 12'h000}, // R5 unarmed read ignored
    '{4'd5, 1'b0,1'b1,1'b1,1'b0, 12'h000, 1'b1,1'b1,1'b1,1'b1,1'b1, 12'h000}, // R5 arm
    '{4'd5, 1'b1,1'b1,1'b0,1'b0, 12'h000, 1'b1,1'b1,1'b1,1'b0,1'b1, 12'h0A1}, // R5 pop first
    '{4'd5, 1'b1,1'b1,1'b0,1'b0, 12'h000, 1'b1,1'b1,1'b0,1'b0,1'b1, 12'h0A2}, // R5 pop second
    '{4'd8, 1'b1,1'b1,1'b0,1'b0, 12'h000, 1'b1,1'b1,1'b0,1'b0,1'b1, 12'h0A2}, // R8 read empty
    '{4'd8, 1'b1,1'b1,1'b1,1'b0, 12'h000, 1'b1,1'b1,1'b0,1'b0,1'b1, 12'h0A2}  // R8 idle
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic we, input logic re,
                     input logic fl, input logic [11:0] d);
    @(negedge clk);
    addr_n = a; wr_en_pin = we; rd_en_pin = re; flush_req = fl; wr_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic flags(input string req, input logic f, input logic h,
                       input logic e);
    check({full_pin, half_n_pin, empty_pin} == {f, h, e}, req,
          {full_pin, half_n_pin, empty_pin}, {f, h, e});
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1; casc_mode = mode; flush_req = 1'b0; addr_n = 1'b1;
    wr_en_pin = ~mode; rd_en_pin = ~mode; wr_data = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    do_reset(1'b0);
    #1;
    // R1 reset state
    flags("R1", 1'b1, 1'b1, 1'b0);
    check(flag_oe == 1'b0 && rd_data == 12'h000, "R1", {flag_oe, rd_data}, 0);

    // R3 R4 R5 R6 R8 table walk
    for (int i = 0; i < 12; i++) begin
      vec_t v;
      v = VECS[i];
      cyc(v.a, v.we, v.re, v.fl, v.d);
      check({full_pin, half_n_pin, empty_pin, flag_oe} ==
            {v.e_full, v.e_half, v.e_empty, v.e_oe},
            $sformatf("R%0d row %0d flags", v.req, i),
            {full_pin, half_n_pin, empty_pin, flag_oe},
            {v.e_full, v.e_half, v.e_empty, v.e_oe});
      if (v.chk_rd)
        check(rd_data == v.e_rd, $sformatf("R%0d row %0d data", v.req, i),
              rd_data, v.e_rd);
    end

    // R7 R8 fill to half and full, then drain in order
    for (int i = 0; i < 256; i++) begin
      cyc((i == 0) ? 1'b0 : 1'b1, 1'b0, 1'b1, 1'b0, 12'(i));
      if (i == 126) check(half_n_pin == 1'b1, "R7 below half", half_n_pin, 1);
      if (i == 127) check(half_n_pin == 1'b0, "R7 at half", half_n_pin, 0);
      if (i == 254) check(full_pin == 1'b1, "R8 not yet full", full_pin, 1);
    end
    flags("R8 full", 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 12'hFFF); // R8 write while full
    flags("R8 write while full", 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 12'h000);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 12'h000); // arm read
    for (int i = 0; i < 256; i++) begin
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
      check(rd_data == 12'(i), "R8 drain order", rd_data, i);
    end
    flags("R8 drained", 1'b1, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
    check(rd_data == 12'd255, "R8 read empty", rd_data, 255);

    // R2 chaining mode: active-high enables, full, empty
    do_reset(1'b1);
    #1;
    flags("R2 cascade reset", 1'b0, 1'b1, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 12'h000); // low levels are idle here
    flags("R2 cascade idle", 1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 12'h5C3);
    flags("R2 cascade write", 1'b0, 1'b1, 1'b0);
    check(flag_oe == 1'b1, "R2 cascade oe", flag_oe, 1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 12'h000); // arm
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 12'h000);
    check(rd_data == 12'h5C3, "R2 cascade read", rd_data, 12'h5C3);
    flags("R2 cascade empty", 1'b0, 1'b1, 1'b1);

    // R9 valid flush
    do_reset(1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 12'h301);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 12'h302);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 12'h303);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 12'h000);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 12'h000);
    flags("R9 flush hold", 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 12'h777); // write during hold
    flags("R9 hold kept", 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 12'h000);
    flags("R9 released empty", 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 12'h000); // arm
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
    check(rd_data == 12'h000, "R9 contents discarded", rd_data, 0);

    // R10 flush with write enable active is ignored
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 12'h000);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 12'h101);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 12'h102);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 12'h103);
    flags("R10 no flush", 1'b1, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 12'h000);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 12'h000); // arm
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 12'h000);
    check(rd_data == 12'h101, "R10 contents kept", rd_data, 12'h101);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule